// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one status byte for each finished transmission that software must hear about. The transmit engine reports each finished frame as a one-cycle event. The event carries an interrupt-on-success request and three error flags: jabber, underrun and maximum collisions. The block stores the qualifying events in arrival order and always shows the oldest stored byte on a byte-wide read port. Any write strobe on that port discards the shown entry, and the next-oldest entry then appears.

While at least one entry waits, the block drives a transmit-complete cause toward the interrupt unit. If completions arrive while every slot is taken, the new entry is lost and the oldest entry is marked so that software can see the loss. A jabber or underrun event locks the transmitter. The lock holds until a transmit reset, which also empties the store.

Top module: `txstat_stack`

## Requirements
- R1: A stored entry reads as a byte in which bit 7 is 1 (complete), bit 6 is the interrupt-on-success request, bit 5 is jabber, bit 4 is underrun, bit 3 is maximum collisions, bit 2 is the overflow mark, and bits 1..0 are 0.
- R2: While nothing is stored, the read port returns 8'h00.
- R3: An event with no error flag is stored only if its interrupt-on-success request is set. An event with any error flag is always offered for storage.
- R4: Entries are presented oldest first.
- R5: A write strobe removes the presented entry on the next clock edge. A write strobe while nothing is stored has no effect.
- R6: An event that arrives while all DEPTH slots are full, with no removal in the same cycle, is dropped. It sets bit 2 of the presented (oldest) entry, and the other entries keep their contents.
- R7: The transmit-complete cause is high exactly while at least one entry is stored. It rises the cycle after the first entry is accepted.
- R8: A jabber or underrun event sets the transmitter lock output from the next cycle on. A maximum-collisions-only event does not set the lock.
- R9: A transmit reset empties the store and clears the lock on the next edge. It takes priority over any event or write strobe in the same cycle.
- R10: The depth is a parameter (default 4). With the default, exactly four entries are held before overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | One-cycle finished-transmission event |
| evt_intr_req | input | 1 | Interrupt requested on success |
| evt_jabber | input | 1 | Jabber error |
| evt_underrun | input | 1 | Underrun error |
| evt_max_coll | input | 1 | Maximum collisions reached |
| stat_wr | input | 1 | Write strobe on the status port (removes head) |
| tx_reset | input | 1 | Transmit reset command |
| stat_rd_data | output | 8 | Oldest status byte, 0 when empty |
| tx_complete_irq | output | 1 | Transmit-complete interrupt cause |
| tx_locked | output | 1 | Transmitter locked pending reset |

## Verification
Assertions check several rules on every cycle: that an empty store reads zero, that the presented byte always carries the complete bit with the low bits clear, that a dropped push leaves the store full, that a removal attempt on an empty store changes nothing, and that a transmit reset empties the store and drops the lock. The byte encoding itself, the oldest-first order, the marking of the head on overflow and the choice of which successes are stored can only be shown by the bench. It does this by comparing a reference queue against the port across fill, drain, overflow and reset-collision scenarios.

// File: rtl/txstat_pkg.sv
// Package: shared entry type and the byte encoding of the status port.
// Assumes the consumer reads bits 1..0 as zero.
package txstat_pkg;

    typedef struct packed {
        logic intr_req;
        logic jabber;
        logic underrun;
        logic max_coll;
        logic ovf;
    } txstat_entry_t;

    // Build the port byte from a stored entry (complete bit always set).
    function automatic logic [7:0] entry_to_byte(input txstat_entry_t e);
        return {1'b1, e.intr_req, e.jabber, e.underrun, e.max_coll, e.ovf, 2'b00};
    endfunction

endpackage

// File: rtl/txstat_encode.sv
// Decides whether a finished-transmission event is stored and whether it
// is fatal. Purely combinational; assumes evt_valid is a single-cycle pulse.
module txstat_encode
    import txstat_pkg::*;
(
    input  logic          evt_valid,
    input  logic          evt_intr_req,
    input  logic          evt_jabber,
    input  logic          evt_underrun,
    input  logic          evt_max_coll,
    output logic          push,
    output txstat_entry_t entry,
    output logic          fatal
);

    logic any_err;

    // Qualify the event and pack the entry fields.
    always_comb begin
        any_err        = evt_jabber | evt_underrun | evt_max_coll;
        push           = evt_valid & (any_err | evt_intr_req);
        fatal          = evt_valid & (evt_jabber | evt_underrun);
        entry.intr_req = evt_intr_req;
        entry.jabber   = evt_jabber;
        entry.underrun = evt_underrun;
        entry.max_coll = evt_max_coll;
        entry.ovf      = 1'b0;
    end

endmodule

// File: rtl/txstat_fifo.sv
// Oldest-first entry store of DEPTH slots. A push while full (without a
// simultaneous pop) is dropped and marks the head entry's overflow bit.
// clr empties the store and wins over push and pop. DEPTH >= 2.
module txstat_fifo
    import txstat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  txstat_entry_t push_entry,
    input  logic          pop,
    output logic          head_valid,
    output txstat_entry_t head_entry
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    txstat_entry_t    slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             empty, full, do_pop, do_push, drop;

    // Derive the accept / drop decisions for this cycle.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        do_pop  = pop & ~empty;
        do_push = push & (~full | do_pop);
        drop    = push & full & ~do_pop;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Write a new entry, or mark overflow on the head slot.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                slots[i] <= '0;
            end else if (do_push && wr_ptr == PTR_W'(i)) begin
                slots[i] <= push_entry;
            end else if (drop && rd_ptr == PTR_W'(i)) begin
                slots[i].ovf <= 1'b1;
            end
        end
    end

    assign head_valid = ~empty;
    assign head_entry = slots[rd_ptr];

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    a_r6_drop_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !clr) |=> full);
    a_r5_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> empty);
    a_r7_push_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && !clr) |=> head_valid);

endmodule

// File: rtl/txstat_lock.sv
// Transmitter lock: set by a fatal event, cleared only by clr (transmit
// reset), which wins in the same cycle.
module txstat_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fatal,
    output logic locked
);

    // Hold the lock until the transmit reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) locked <= 1'b0;
        else if (fatal)    locked <= 1'b1;
    end

    a_r8_fatal_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal && !clr) |=> locked);
    a_r9_reset_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !locked);

endmodule

// File: rtl/txstat_stack.sv
// Top: transmit completion status stack. Qualifies events, stores them
// oldest first, presents the head byte, pops on a port write, raises the
// transmit-complete cause while non-empty, and locks on fatal errors.
module txstat_stack
    import txstat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_valid,
    input  logic       evt_intr_req,
    input  logic       evt_jabber,
    input  logic       evt_underrun,
    input  logic       evt_max_coll,
    input  logic       stat_wr,
    input  logic       tx_reset,
    output logic [7:0] stat_rd_data,
    output logic       tx_complete_irq,
    output logic       tx_locked
);

    logic          enc_push, enc_fatal, head_valid;
    txstat_entry_t enc_entry, head_entry;

    txstat_encode u_encode (
        .evt_valid    (evt_valid),
        .evt_intr_req (evt_intr_req),
        .evt_jabber   (evt_jabber),
        .evt_underrun (evt_underrun),
        .evt_max_coll (evt_max_coll),
        .push         (enc_push),
        .entry        (enc_entry),
        .fatal        (enc_fatal)
    );

    txstat_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tx_reset),
        .push       (enc_push),
        .push_entry (enc_entry),
        .pop        (stat_wr),
        .head_valid (head_valid),
        .head_entry (head_entry)
    );

    txstat_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tx_reset),
        .fatal  (enc_fatal),
        .locked (tx_locked)
    );

    // Present the head byte, or zero when empty.
    always_comb begin
        stat_rd_data    = head_valid ? entry_to_byte(head_entry) : 8'h00;
        tx_complete_irq = head_valid;
    end

    a_r2_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_complete_irq |-> (stat_rd_data == 8'h00));
    a_r1_head_layout: assert property (@(posedge clk) disable iff (!rst_n)
        tx_complete_irq |-> (stat_rd_data[7] && stat_rd_data[1:0] == 2'b00));

endmodule

// File: tb/txstat_stack_bench.sv
`timescale 1ns/1ps
module txstat_stack_bench;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 0, evt_intr_req = 0, evt_jabber = 0;
    logic       evt_underrun = 0, evt_max_coll = 0, stat_wr = 0, tx_reset = 0;
    logic [7:0] stat_rd_data;
    logic       tx_complete_irq, tx_locked;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] exp_q [$];
    logic       exp_lock = 1'b0;

    always #4 clk = ~clk;

    txstat_stack #(.DEPTH(DEPTH)) u_txstat_stack (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_intr_req(evt_intr_req),
        .evt_jabber(evt_jabber), .evt_underrun(evt_underrun), .evt_max_coll(evt_max_coll),
        .stat_wr(stat_wr), .tx_reset(tx_reset), .stat_rd_data(stat_rd_data),
        .tx_complete_irq(tx_complete_irq), .tx_locked(tx_locked)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Driver: one event for one cycle; the reference queue follows the requirements.
    task automatic drive_evt(input logic ir, input logic jb, input logic ur, input logic mc,
                             input logic rst_too);
        @(negedge clk);
        evt_valid = 1; evt_intr_req = ir; evt_jabber = jb; evt_underrun = ur;
        evt_max_coll = mc; tx_reset = rst_too;
        @(negedge clk);
        evt_valid = 0; evt_intr_req = 0; evt_jabber = 0; evt_underrun = 0;
        evt_max_coll = 0; tx_reset = 0;
        if (rst_too) begin
            exp_q.delete(); exp_lock = 1'b0;
        end else begin
            if (jb || ur) exp_lock = 1'b1;
            if (ir || jb || ur || mc) begin
                if (exp_q.size() == DEPTH) exp_q[0] = exp_q[0] | 8'h04;
                else exp_q.push_back({1'b1, ir, jb, ur, mc, 3'b000});
            end
        end
    endtask

    // Monitor: compare the head with the reference, then pop it.
    task automatic pop_check(input string req);
        logic [7:0] exp;
        exp = (exp_q.size() == 0) ? 8'h00 : exp_q[0];
        chk(req, stat_rd_data, exp);
        @(negedge clk); stat_wr = 1;
        @(negedge clk); stat_wr = 0;
        if (exp_q.size() != 0) void'(exp_q.pop_front());
    endtask

    task automatic check_side(input string req);
        chk({req, " irq"}, {7'd0, tx_complete_irq}, {7'd0, exp_q.size() != 0});
        chk({req, " lock"}, {7'd0, tx_locked}, {7'd0, exp_lock});
    endtask

    task automatic pulse_tx_reset();
        @(negedge clk); tx_reset = 1;
        @(negedge clk); tx_reset = 0;
        exp_q.delete(); exp_lock = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2 reset data", stat_rd_data, 8'h00);
        check_side("R7 reset");

        drive_evt(0, 0, 0, 0, 0);                 // R3: plain success, not stored
        chk("R3 silent success", stat_rd_data, 8'h00);
        check_side("R3");

        drive_evt(1, 0, 0, 0, 0);                 // R1: 0xC0
        chk("R1 success with request", stat_rd_data, 8'hC0);
        check_side("R7 raised");
        drive_evt(0, 0, 0, 1, 0);                 // R3/R8: max collisions, no lock
        check_side("R8 maxcoll no lock");
        pop_check("R4 first");
        pop_check("R4 second 0x88");
        check_side("R5 drained");
        pop_check("R5 pop on empty");
        chk("R5 empty stays zero", stat_rd_data, 8'h00);

        for (int i = 0; i < DEPTH + 2; i++)       // R6/R10: overflow on default depth
            drive_evt(1, 0, 0, (i % 2) == 1, 0);
        chk("R6 head overflow mark", stat_rd_data, 8'hC4);
        for (int i = 0; i < DEPTH + 1; i++) pop_check("R10 drain after overflow");
        check_side("R10 empty after depth pops");

        drive_evt(0, 0, 1, 0, 0);                 // R8: underrun locks
        chk("R1 underrun byte", stat_rd_data, 8'h90);
        check_side("R8 underrun");
        drive_evt(0, 1, 0, 0, 0);
        pulse_tx_reset();                          // R9
        chk("R9 cleared data", stat_rd_data, 8'h00);
        check_side("R9 after reset");

        drive_evt(1, 1, 0, 0, 1);                 // R9: reset wins over same-cycle jabber
        chk("R9 priority data", stat_rd_data, 8'h00);
        check_side("R9 priority");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule